// File: doc/BRIEF.md
# Radix-2^3 Delay-Feedback Butterfly Lane

This block is one lane of a 64-point decimation-in-frequency pipelined FFT. Complex samples arrive one per accepted cycle, in natural order, in frames of 64. Inside the lane three radix-2 butterfly steps run in cascade. Each step has its own feedback buffer, of 32, 16 and 8 words. A step holds the first half of each block in its buffer until the partner sample arrives. It then emits the sum at once and recirculates the difference through the same buffer. Between the steps the lane rotates samples by fixed factors. Each of these is a swap with a negation, or a shift-add scaling by an approximation of 1/sqrt(2), so no general multiplier is needed.

After the third step the lane presents each sample together with the exponent e of the twiddle W64^e that a downstream general multiplier must apply. Four such lanes run side by side in a full transform. A small two-state controller (FILL, then RUN) tracks the sample position within the frame. It gates the output valid flag until the pipeline holds a complete frame's worth of history. The input valid signal acts as a clock enable for the whole lane: a cycle without it changes nothing.

Top module: `r23_sdf_bfly`

## Requirements
- R1: While rst_n is low the lane returns to state FILL with the frame position at zero, and out_valid, out_re, out_im and out_tw are all zero.
- R2: For a frame x[0..63], the first step at frame position p produces x[p]+x[p+32] for p<32 and x[p-32]-x[p] for p>=32.
- R3: After the first step, the sample at position p is multiplied by -j (re'=im, im'=-re) when bits 5 and 4 of p are both one; otherwise it passes unchanged.
- R4: The second step combines positions 16 apart within each 32-block, sum first and difference second. The result at position q is then rotated by W8^e, with e = q[3]*(q[5]+2*q[4]). Here e=0 is identity, e=2 is -j, e=1 gives ((re+im)s, (im-re)s) and e=3 gives ((im-re)s, (-re-im)s).
- R5: The scaling s(v) is exactly (v>>>1)+(v>>>3)+(v>>>4)+(v>>>6)+(v>>>8), using arithmetic shifts that round toward minus infinity.
- R6: The third step combines positions 8 apart within each 16-block, sum first and difference second, with no rotation. The result is out_re/out_im as signed IW+4-bit values.
- R7: With r the output position in the frame, out_tw equals r[2:0]*(r[5]+2*r[4]+4*r[3]) (range 0 to 49). It is therefore zero whenever r[2:0] is zero.
- R8: Output position r of frame f appears, with out_valid high, in the cycle after input sample 64*f+56+r (counted from reset) is accepted. out_valid never rises before the 57th accepted sample.
- R9: A cycle with in_valid low leaves out_valid low in the next cycle and leaves out_re, out_im and out_tw unchanged. The lane state does not advance, and in_re/in_im are ignored.
- R10: A reset in the middle of a frame discards that frame. The first sample accepted after reset is position 0 of a new frame, and R8 counts afresh from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample accepted this cycle; lane enable |
| in_re | input | IW | Real part, two's complement |
| in_im | input | IW | Imaginary part, two's complement |
| out_valid | output | 1 | Output sample valid |
| out_re | output | IW+4 | Real part after three steps |
| out_im | output | IW+4 | Imaginary part after three steps |
| out_tw | output | 6 | Exponent e of the W64^e rotation still to apply |

## Verification
The hardest situation to reach is a stall that falls exactly when a step is switching between filling its buffer and combining pairs. At that moment a missed enable would misalign the pairing of one step for the rest of the frame. The stimulus interleaves idle cycles every seventh cycle from the third frame on, so that stalls land on every phase of all three counters over several frames. A reset is also issued part-way through a frame of junk. Then a fresh stream checks that framing restarts from position zero.

// File: rtl/r23_pkg.sv
package r23_pkg;
    localparam int FRAME_LOG2 = 6;
    localparam int FRAME_N    = 1 << FRAME_LOG2;
    localparam int N_STEPS    = 3;
    // samples that must be accepted before the first valid output
    localparam int PRIME_LEN  = FRAME_N - (FRAME_N >> N_STEPS);

    typedef enum logic [0:0] {
        ST_FILL,
        ST_RUN
    } lane_state_e;
endpackage

// File: rtl/r23_ctrl.sv
module r23_ctrl
    import r23_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    output logic                     run,
    output logic [N_STEPS-1:0]       bf_sel,
    output logic [N_STEPS-2:0][1:0]  rot_sel,
    output logic [5:0]               tw
);
    localparam logic [FRAME_LOG2-1:0] FILL_LAST = FRAME_LOG2'(PRIME_LEN - 1);

    lane_state_e             state, state_nx;
    logic [FRAME_LOG2-1:0]   cnt;
    logic [1:0]              pos0_hi;
    logic [2:0]              pos1_hi;
    logic [2:0]              pos2_hi;
    logic [2:0]              n_lo;
    logic [2:0]              k_rev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FILL;
            cnt   <= '0;
        end else if (en) begin
            state <= state_nx;
            cnt   <= cnt + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FILL: if (cnt == FILL_LAST) state_nx = ST_RUN;
            ST_RUN:  state_nx = ST_RUN;
        endcase
    end

    always_comb begin
        run = (state == ST_RUN);
        for (int s = 0; s < N_STEPS; s++) begin
            bf_sel[s] = cnt[FRAME_LOG2-1-s];
        end
        // frame position seen at the output of each step
        pos0_hi = cnt[5:4] + 2'd2;
        pos1_hi = cnt[5:3] + 3'd2;
        pos2_hi = cnt[5:3] + 3'd1;
        rot_sel[0] = (pos0_hi[1] & pos0_hi[0]) ? 2'd2 : 2'd0;
        rot_sel[1] = pos1_hi[0] ? {pos1_hi[1], pos1_hi[2]} : 2'd0;
        n_lo  = cnt[2:0];
        k_rev = {pos2_hi[0], pos2_hi[1], pos2_hi[2]};
        tw    = {3'b000, n_lo} * {3'b000, k_rev};
    end
endmodule

// File: rtl/r23_r2step.sv
module r23_r2step #(
    parameter int W     = 16,
    parameter int DEPTH = 32
) (
    input  logic                clk,
    input  logic                en,
    input  logic                sel,
    input  logic signed [W-1:0] din_re,
    input  logic signed [W-1:0] din_im,
    output logic signed [W-1:0] dout_re,
    output logic signed [W-1:0] dout_im
);
    logic signed [W-1:0] buf_re [DEPTH];
    logic signed [W-1:0] buf_im [DEPTH];
    logic signed [W-1:0] old_re, old_im;
    logic signed [W-1:0] fb_re, fb_im;

    always_ff @(posedge clk) begin
        if (en) begin
            buf_re[0] <= fb_re;
            buf_im[0] <= fb_im;
            for (int k = 1; k < DEPTH; k++) begin
                buf_re[k] <= buf_re[k-1];
                buf_im[k] <= buf_im[k-1];
            end
        end
    end

    always_comb begin
        old_re = buf_re[DEPTH-1];
        old_im = buf_im[DEPTH-1];
        if (sel) begin
            dout_re = old_re + din_re;
            dout_im = old_im + din_im;
            fb_re   = old_re - din_re;
            fb_im   = old_im - din_im;
        end else begin
            dout_re = old_re;
            dout_im = old_im;
            fb_re   = din_re;
            fb_im   = din_im;
        end
    end
endmodule

// File: rtl/r23_rot.sv
module r23_rot #(
    parameter int W = 16
) (
    input  logic [1:0]          sel,
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] r,
    output logic signed [W-1:0] i
);
    function automatic logic signed [W-1:0] halfroot(input logic signed [W-1:0] v);
        return (v >>> 1) + (v >>> 3) + (v >>> 4) + (v >>> 6) + (v >>> 8);
    endfunction

    logic signed [W-1:0] s_ab, d_ba, n_ab;

    always_comb begin
        s_ab = a + b;
        d_ba = b - a;
        n_ab = -a - b;
        unique case (sel)
            2'd0: begin r = a;               i = b;               end
            2'd1: begin r = halfroot(s_ab);  i = halfroot(d_ba);  end
            2'd2: begin r = b;               i = -a;              end
            2'd3: begin r = halfroot(d_ba);  i = halfroot(n_ab);  end
        endcase
    end
endmodule

// File: rtl/r23_sdf_bfly.sv
module r23_sdf_bfly
    import r23_pkg::*;
#(
    parameter int IW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [IW-1:0] in_re,
    input  logic signed [IW-1:0] in_im,
    output logic                 out_valid,
    output logic signed [IW+3:0] out_re,
    output logic signed [IW+3:0] out_im,
    output logic [5:0]           out_tw
);
    localparam int OW = IW + 4;

    logic                    run;
    logic [N_STEPS-1:0]      bf_sel;
    logic [N_STEPS-2:0][1:0] rot_sel;
    logic [5:0]              tw;
    logic signed [OW-1:0]    st_re [N_STEPS+1];
    logic signed [OW-1:0]    st_im [N_STEPS+1];

    r23_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (in_valid),
        .run     (run),
        .bf_sel  (bf_sel),
        .rot_sel (rot_sel),
        .tw      (tw)
    );

    assign st_re[0] = {{(OW-IW){in_re[IW-1]}}, in_re};
    assign st_im[0] = {{(OW-IW){in_im[IW-1]}}, in_im};

    for (genvar s = 0; s < N_STEPS; s++) begin : g_step
        localparam int DEP = FRAME_N >> (s + 1);
        logic signed [OW-1:0] bf_re, bf_im;

        r23_r2step #(.W(OW), .DEPTH(DEP)) u_step (
            .clk     (clk),
            .en      (in_valid),
            .sel     (bf_sel[s]),
            .din_re  (st_re[s]),
            .din_im  (st_im[s]),
            .dout_re (bf_re),
            .dout_im (bf_im)
        );

        if (s < N_STEPS - 1) begin : g_rot
            r23_rot #(.W(OW)) u_rot (
                .sel (rot_sel[s]),
                .a   (bf_re),
                .b   (bf_im),
                .r   (st_re[s+1]),
                .i   (st_im[s+1])
            );
        end else begin : g_last
            assign st_re[s+1] = bf_re;
            assign st_im[s+1] = bf_im;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
            out_tw    <= '0;
        end else begin
            out_valid <= in_valid & run;
            if (in_valid && run) begin
                out_re <= st_re[N_STEPS];
                out_im <= st_im[N_STEPS];
                out_tw <= tw;
            end
        end
    end
endmodule

// File: rtl/r23_sdf_bfly_chk.sv
module r23_sdf_bfly_chk #(
    parameter int IW = 12
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           out_valid,
    input logic [IW+3:0]  out_re,
    input logic [IW+3:0]  out_im,
    input logic [5:0]     out_tw
);
    localparam logic [5:0] PRIMED = 6'd57;

    logic [5:0] acc;
    logic [5:0] opos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '0;
            opos <= '0;
        end else begin
            if (in_valid && acc != PRIMED) acc <= acc + 1'b1;
            if (out_valid) opos <= opos + 1'b1;
        end
    end

    AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> acc >= PRIMED); // R8
    AST_OUT_FOLLOWS_IN: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && acc >= 6'd56) |=> out_valid); // R8
    AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> ($stable(out_re) && $stable(out_im) && $stable(out_tw))); // R9
    AST_TW_ZERO_COL: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && opos[2:0] == 3'd0) |-> out_tw == 6'd0); // R7
    AST_TW_RANGE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> out_tw <= 6'd49); // R7
endmodule

bind r23_sdf_bfly r23_sdf_bfly_chk #(.IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im),
    .out_tw    (out_tw)
);

// File: tb/sim_r23_sdf_bfly.sv
`timescale 1ns/1ps
module sim_r23_sdf_bfly;
    localparam int IW = 12;
    localparam int OW = IW + 4;
    localparam int NS = 384;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [IW-1:0] in_re = '0;
    logic signed [IW-1:0] in_im = '0;
    logic                 out_valid;
    logic signed [OW-1:0] out_re, out_im;
    logic [5:0]           out_tw;

    int xr[NS], xi[NS], er[NS], ei[NS], etw[NS];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    r23_sdf_bfly #(.IW(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im), .out_tw(out_tw)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int hr(input int v);
        return (v >>> 1) + (v >>> 3) + (v >>> 4) + (v >>> 6) + (v >>> 8);
    endfunction

    task automatic rotate(input int e, input int a, input int b, output int r, output int i);
        case (e)
            0: begin r = a;         i = b;          end
            1: begin r = hr(a + b); i = hr(b - a);  end
            2: begin r = b;         i = -a;         end
            default: begin r = hr(b - a); i = hr(-a - b); end
        endcase
    endtask

    // expected values per frame, computed from the requirement formulas
    task automatic build_expected();
        for (int f = 0; f < NS / 64; f++) begin
            int ar[64], ai[64], tr[64], ti[64];
            for (int p = 0; p < 64; p++) begin
                ar[p] = xr[f*64+p];
                ai[p] = xi[f*64+p];
            end
            for (int st = 0; st < 3; st++) begin
                int h;
                h = 32 >> st;
                for (int p = 0; p < 64; p++) begin
                    int base, m;
                    base = (p / (2*h)) * (2*h);
                    m = p % (2*h);
                    if (m < h) begin
                        tr[p] = ar[base+m] + ar[base+m+h];
                        ti[p] = ai[base+m] + ai[base+m+h];
                    end else begin
                        tr[p] = ar[base+m-h] - ar[base+m];
                        ti[p] = ai[base+m-h] - ai[base+m];
                    end
                end
                for (int p = 0; p < 64; p++) begin
                    int e;
                    e = 0;
                    if (st == 0 && ((p >> 5) & 1) == 1 && ((p >> 4) & 1) == 1) e = 2;
                    if (st == 1 && ((p >> 3) & 1) == 1) e = ((p >> 5) & 1) + 2 * ((p >> 4) & 1);
                    rotate(e, tr[p], ti[p], ar[p], ai[p]);
                end
            end
            for (int p = 0; p < 64; p++) begin
                er[f*64+p]  = ar[p];
                ei[f*64+p]  = ai[p];
                etw[f*64+p] = (p & 7) * (((p >> 5) & 1) + 2 * ((p >> 4) & 1) + 4 * ((p >> 3) & 1));
            end
        end
    endtask

    task automatic make_stim(input int seed);
        int s;
        s = seed;
        for (int g = 0; g < NS; g++) begin
            int f, n;
            f = g / 64;
            n = g % 64;
            case (f)
                0: begin xr[g] = (n == 5) ? 1000 : 0; xi[g] = (n == 9) ? -700 : 0; end
                1: begin xr[g] = 2047; xi[g] = -2048; end
                4: begin xr[g] = (n % 2 == 0) ? 2047 : -2048; xi[g] = (n % 3 == 0) ? -2048 : 2047; end
                5: begin xr[g] = 0; xi[g] = 0; end
                default: begin
                    s = s * 1103515245 + 12345;
                    xr[g] = ((s >> 16) & 4095) - 2048;
                    s = s * 1103515245 + 12345;
                    xi[g] = ((s >> 16) & 4095) - 2048;
                end
            endcase
        end
        build_expected();
    endtask

    task automatic run_stream();
        int g, cyc, pidx;
        bit pend, last_v;
        logic signed [OW-1:0] pr_re, pr_im;
        logic [5:0] pr_tw;
        g = 0; cyc = 0; pend = 0; last_v = 1; pidx = 0;
        pr_re = out_re; pr_im = out_im; pr_tw = out_tw;
        while (g < NS || pend) begin
            bit v;
            @(negedge clk);
            if (pend) begin
                chk(out_valid == 1'b1, "R8", "out_valid at expected slot", int'(out_valid), 1);
                chk(int'(out_re) == er[pidx], "R2 R3 R4 R5 R6", $sformatf("out_re pos %0d", pidx), int'(out_re), er[pidx]);
                chk(int'(out_im) == ei[pidx], "R2 R3 R4 R5 R6", $sformatf("out_im pos %0d", pidx), int'(out_im), ei[pidx]);
                chk(int'(out_tw) == etw[pidx], "R7", $sformatf("out_tw pos %0d", pidx), int'(out_tw), etw[pidx]);
            end else if (!last_v) begin
                chk(out_valid == 1'b0, "R9", "out_valid after idle", int'(out_valid), 0);
                chk(out_re == pr_re && out_im == pr_im && out_tw == pr_tw, "R9", "outputs held after idle",
                    int'(out_re), int'(pr_re));
            end else begin
                chk(out_valid == 1'b0, "R8", "out_valid during fill", int'(out_valid), 0);
            end
            pr_re = out_re; pr_im = out_im; pr_tw = out_tw;
            v = (g < NS) && !(g >= 128 && (cyc % 7) == 3);
            if (v) begin
                in_valid = 1'b1;
                in_re = IW'(xr[g]);
                in_im = IW'(xi[g]);
                pend = (g >= 56);
                pidx = g - 56;
                g++;
            end else begin
                in_valid = 1'b0;
                in_re = 12'sh5A5;
                in_im = -12'sh3C3;
                pend = 0;
            end
            last_v = v;
            cyc++;
        end
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        chk(out_re == '0 && out_im == '0, "R1", "data in reset", int'(out_re), 0);
        chk(out_tw == 6'd0, "R1", "out_tw in reset", int'(out_tw), 0);
        rst_n = 1'b1;
        make_stim(7);
        run_stream();

        // R10: reset part-way through a junk frame, then a fresh stream
        repeat (2) @(negedge clk);
        for (int k = 0; k < 41; k++) begin
            in_valid = 1'b1;
            in_re = IW'(k * 37 - 900);
            in_im = IW'(500 - k * 29);
            @(negedge clk);
        end
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10", "out_valid after mid-frame reset", int'(out_valid), 0);
        chk(out_tw == 6'd0, "R1", "out_tw after mid-frame reset", int'(out_tw), 0);
        @(negedge clk);
        rst_n = 1'b1;
        make_stim(12345);
        run_stream();
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R9", "quiet after stream end", int'(out_valid), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R8 watchdog expired: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule